// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block turns a four-bit operating-mode field into gate enables for the system's clocks and oscillator resources. It drives five enables: the main (CPU) clock, the sub-main (peripheral) clock, the auxiliary clock, the DCO dc generator and the crystal oscillator. Software loads the mode field to choose active mode or one of five sleep levels. The enables follow from the individual bits, with one asymmetric rule for the DCO dc generator.

An interrupt-entry strobe saves the current mode on a small last-in-first-out store and forces active mode, so the main clock comes back within one clock cycle even from the deepest sleep level. An interrupt-return strobe restores the most recently saved mode. Each enable is re-timed on the falling edge of the controller clock, so a downstream AND-type clock gate only sees an enable change while the gated clock is low.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `mode_o` is 4'b0000 (active mode) and all five enables are 1.
- R2: The mode field bits are: bit 0 CPU-off, bit 1 oscillator-off, bit 2 clock-gen-0, bit 3 clock-gen-1. A cycle with `sr_wr` high loads `sr_wdata` into `mode_o` at the next rising edge. The named modes are AM=0000, LPM0=0001, LPM1=0101, LPM2=1001, LPM3=1101 and LPM4=1111.
- R3: `mclk_en` is the inverse of bit 0, `smclk_en` is the inverse of bit 3, and `aclk_en` and `xosc_en` are both the inverse of bit 1, each bit acting on its own.
- R4: `dcogen_en` is 1 when bit 2 is clear. It is also 1 when bit 2 is set, bit 3 is clear and `dco_main` is 1. Otherwise it is 0. So the generator is off in LPM1 only when the DCO does not source the main clock, on in LPM2, and off in LPM3.
- R5: In LPM4 all five enables are 0.
- R6: A cycle with `irq_enter` high saves the current mode and sets `mode_o` to 0000 at the next rising edge. `mclk_en` is 1 by the falling edge that follows.
- R7: A cycle with `irq_return` high restores the most recently saved mode. Saves nest in last-in-first-out order, up to STACK_DEPTH levels.
- R8: `irq_return` with no saved mode leaves `mode_o` and the enables unchanged.
- R9: The enables change only on the falling edge of `clk`, half a cycle after the rising edge that updates `mode_o`.
- R10: `irq_enter` takes priority over `irq_return` and `sr_wr` in the same cycle. `irq_return` takes priority over `sr_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, always running |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_wr | input | 1 | Load strobe for the mode field |
| sr_wdata | input | 4 | Mode field value to load |
| dco_main | input | 1 | 1 when the DCO sources the main clock in active mode |
| irq_enter | input | 1 | Interrupt-entry strobe: save mode, force active |
| irq_return | input | 1 | Interrupt-return strobe: restore saved mode |
| mclk_en | output | 1 | Main clock gate enable |
| smclk_en | output | 1 | Sub-main clock gate enable |
| aclk_en | output | 1 | Auxiliary clock gate enable |
| dcogen_en | output | 1 | DCO dc generator enable |
| xosc_en | output | 1 | Crystal oscillator enable |
| mode_o | output | 4 | Current mode field |

## Verification
The bench checks the conditional DCO rule in LPM1 with `dco_main` at both values. A design that keys the generator on bit 2 alone would wrongly turn it off in LPM1 while the DCO runs the CPU. The bench nests two interrupts and then issues one return too many. A design that uses a single save register, or lets an empty return pop stale data, would restore the wrong mode. The bench pulses strobes in the same cycle to check that a simultaneous mode write or return cannot stop the wake-up. It also samples just before and just after the falling edge when waking from LPM4, which catches an enable that is driven straight from the decode, or one that is delayed by a full cycle.

// File: rtl/lpm_pkg.sv
// Shared constants and types for the low-power mode clock controller.
// Assumes a four-bit mode field and five gate enables; positions below are
// relied on by the decode and by software that writes the mode field.
package lpm_pkg;
    localparam int SR_W      = 4;
    localparam int SR_CPUOFF = 0;
    localparam int SR_OSCOFF = 1;
    localparam int SR_SCG0   = 2;
    localparam int SR_SCG1   = 3;

    localparam int NUM_EN    = 5;
    localparam int EN_MCLK   = 0;
    localparam int EN_SMCLK  = 1;
    localparam int EN_ACLK   = 2;
    localparam int EN_DCOGEN = 3;
    localparam int EN_XOSC   = 4;

    typedef logic [SR_W-1:0]   sr_t;
    typedef logic [NUM_EN-1:0] en_t;

    localparam sr_t SR_ACTIVE = '0;
    localparam sr_t SR_LPM3   = 4'b1101;
    localparam sr_t SR_LPM4   = 4'b1111;
endpackage

// File: rtl/lpm_mode_state.sv
// Mode field register with a LIFO save store for interrupt nesting.
// Assumes single-cycle strobes; entry beats return, return beats write.
// A save beyond STACK_DEPTH still forces active mode but is not recorded.
// STACK_DEPTH must be at least 2.
module lpm_mode_state
    import lpm_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  sr_t  wr_mode,
    input  logic enter,
    input  logic leave,
    output sr_t  mode
);
    localparam int IDX_W = $clog2(STACK_DEPTH);
    localparam int CNT_W = $clog2(STACK_DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(STACK_DEPTH);

    sr_t              stk [STACK_DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] push_idx;
    logic [IDX_W-1:0] pop_idx;

    // Index of the free slot and of the most recent saved entry.
    always_comb begin
        push_idx = cnt[IDX_W-1:0];
        pop_idx  = IDX_W'(cnt - CNT_W'(1));
    end

    // Mode register and save store update, in strobe priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= SR_ACTIVE;
            cnt  <= '0;
            for (int i = 0; i < STACK_DEPTH; i++) stk[i] <= SR_ACTIVE;
        end else if (enter) begin
            if (cnt < CNT_FULL) begin
                stk[push_idx] <= mode;
                cnt           <= cnt + CNT_W'(1);
            end
            mode <= SR_ACTIVE;
        end else if (leave) begin
            if (cnt != '0) begin
                mode <= stk[pop_idx];
                cnt  <= cnt - CNT_W'(1);
            end
        end else if (wr_en) begin
            mode <= wr_mode;
        end
    end
endmodule

// File: rtl/lpm_clk_decode.sv
// Maps the mode field to raw (not yet re-timed) clock and oscillator enables.
// Assumes dco_main is a quasi-static configuration level.
module lpm_clk_decode
    import lpm_pkg::*;
(
    input  sr_t  mode,
    input  logic dco_main,
    output en_t  en
);
    // Per-bit gating, with the DCO generator kept alive in LPM1 when it feeds MCLK.
    always_comb begin
        en             = '0;
        en[EN_MCLK]    = ~mode[SR_CPUOFF];
        en[EN_SMCLK]   = ~mode[SR_SCG1];
        en[EN_ACLK]    = ~mode[SR_OSCOFF];
        en[EN_XOSC]    = ~mode[SR_OSCOFF];
        en[EN_DCOGEN]  = ~mode[SR_SCG0] | (dco_main & ~mode[SR_SCG1]);
    end
endmodule

// File: rtl/lpm_en_sync.sv
// Re-times one enable on the falling clock edge so that a downstream
// AND-type gate only sees it change while the clock is low.
// Assumes the same clk that the gated clock is derived from.
module lpm_en_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // Falling-edge capture of the raw enable.
    always_ff @(negedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end
endmodule

// File: rtl/lpm_clk_ctrl.sv
// Low-power mode clock controller top: mode register with interrupt save and
// restore, enable decode, and falling-edge re-timing of every enable.
// Assumes clk keeps running in every mode and strobes last one cycle.
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sr_wr,
    input  logic [3:0]  sr_wdata,
    input  logic        dco_main,
    input  logic        irq_enter,
    input  logic        irq_return,
    output logic        mclk_en,
    output logic        smclk_en,
    output logic        aclk_en,
    output logic        dcogen_en,
    output logic        xosc_en,
    output logic [3:0]  mode_o
);
    sr_t mode;
    en_t en_raw;
    en_t en_q;

    lpm_mode_state #(.STACK_DEPTH(STACK_DEPTH)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sr_wr),
        .wr_mode (sr_wdata),
        .enter   (irq_enter),
        .leave   (irq_return),
        .mode    (mode)
    );

    lpm_clk_decode u_dec (
        .mode     (mode),
        .dco_main (dco_main),
        .en       (en_raw)
    );

    for (genvar g = 0; g < NUM_EN; g++) begin : g_sync
        lpm_en_sync #(.RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (en_raw[g]),
            .q     (en_q[g])
        );
    end

    // Drive the named output pins from the re-timed enable vector.
    always_comb begin
        mclk_en   = en_q[EN_MCLK];
        smclk_en  = en_q[EN_SMCLK];
        aclk_en   = en_q[EN_ACLK];
        dcogen_en = en_q[EN_DCOGEN];
        xosc_en   = en_q[EN_XOSC];
        mode_o    = mode;
    end
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
// Property checker for lpm_clk_ctrl, attached with bind below.
// Assumes it is sampled on the rising edge, when every enable already
// reflects the mode field that was registered on the previous rising edge.
module lpm_clk_ctrl_chk
    import lpm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       irq_enter,
    input logic       mclk_en,
    input logic       smclk_en,
    input logic       aclk_en,
    input logic       dcogen_en,
    input logic       xosc_en,
    input logic [3:0] mode_o
);
    p_mclk_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en == !mode_o[SR_CPUOFF]);

    p_smclk_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smclk_en == !mode_o[SR_SCG1]);

    p_dco_off_lpm3_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == SR_LPM3) |-> !dcogen_en);

    p_all_off_lpm4_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == SR_LPM4) |-> !(mclk_en | smclk_en | aclk_en | dcogen_en | xosc_en));

    p_wake_mclk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> mclk_en);

    p_enter_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> (mode_o == SR_ACTIVE));
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_enter (irq_enter),
    .mclk_en   (mclk_en),
    .smclk_en  (smclk_en),
    .aclk_en   (aclk_en),
    .dcogen_en (dcogen_en),
    .xosc_en   (xosc_en),
    .mode_o    (mode_o)
);

// File: tb/tb_lpm_clk_ctrl.sv
module tb_lpm_clk_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 5000;

    // Vector: {mode[3:0], dco_main, expected {xosc,dcogen,aclk,smclk,mclk}}
    localparam int NVEC = 9;
    localparam logic [9:0] VEC [NVEC] = '{
        {4'b0000, 1'b0, 5'b11111},   // AM
        {4'b0001, 1'b0, 5'b11110},   // LPM0
        {4'b0101, 1'b0, 5'b10110},   // LPM1, DCO not main
        {4'b0101, 1'b1, 5'b11110},   // LPM1, DCO main
        {4'b1001, 1'b0, 5'b11100},   // LPM2
        {4'b1101, 1'b0, 5'b10100},   // LPM3
        {4'b1101, 1'b1, 5'b10100},   // LPM3, DCO main
        {4'b1111, 1'b1, 5'b00000},   // LPM4
        {4'b0010, 1'b0, 5'b01011}    // oscillator-off alone
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sr_wr;
    logic [3:0] sr_wdata;
    logic       dco_main;
    logic       irq_enter;
    logic       irq_return;
    logic       mclk_en, smclk_en, aclk_en, dcogen_en, xosc_en;
    logic [3:0] mode_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_clk_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_wr      (sr_wr),
        .sr_wdata   (sr_wdata),
        .dco_main   (dco_main),
        .irq_enter  (irq_enter),
        .irq_return (irq_return),
        .mclk_en    (mclk_en),
        .smclk_en   (smclk_en),
        .aclk_en    (aclk_en),
        .dcogen_en  (dcogen_en),
        .xosc_en    (xosc_en),
        .mode_o     (mode_o)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] ens();
        return {xosc_en, dcogen_en, aclk_en, smclk_en, mclk_en};
    endfunction

    task automatic write_mode(input logic [3:0] m);
        sr_wr = 1'b1; sr_wdata = m;
        step();
        sr_wr = 1'b0;
        step();
    endtask

    task automatic pulse_enter();
        irq_enter = 1'b1;
        step();
        irq_enter = 1'b0;
        step();
    endtask

    task automatic pulse_return();
        irq_return = 1'b1;
        step();
        irq_return = 1'b0;
        step();
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sr_wr = 1'b0; sr_wdata = '0; dco_main = 1'b0;
        irq_enter = 1'b0; irq_return = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset mode", mode_o, 4'b0000);
        chk("R1 reset enables", ens(), 5'b11111);

        // R2 R3 R4 R5: table of mode encodings
        for (int i = 0; i < NVEC; i++) begin
            dco_main = VEC[i][5];
            write_mode(VEC[i][9:6]);
            chk("R2 mode load", mode_o, VEC[i][9:6]);
            chk("R3/R4/R5 enables", ens(), VEC[i][4:0]);
        end

        // R6 R9: wake from LPM4, enables move only at the falling edge
        dco_main = 1'b0;
        write_mode(4'b1111);
        chk("R5 lpm4 off", ens(), 5'b00000);
        irq_enter = 1'b1;
        step();
        irq_enter = 1'b0;
        chk("R6 mode cleared", mode_o, 4'b0000);
        chk("R9 mclk waits falling edge", mclk_en, 1'b0);
        #(CLK_PERIOD/2);
        chk("R6 mclk up after falling edge", mclk_en, 1'b1);
        chk("R6 all enables up", ens(), 5'b11111);
        step();
        pulse_return();
        chk("R7 back to lpm4", mode_o, 4'b1111);
        chk("R7 lpm4 enables", ens(), 5'b00000);

        // R7 R8: nested entries then one return too many
        write_mode(4'b1101);
        pulse_enter();
        write_mode(4'b0001);
        pulse_enter();
        chk("R6 nested active", mode_o, 4'b0000);
        pulse_return();
        chk("R7 inner restore", mode_o, 4'b0001);
        chk("R7 inner enables", ens(), 5'b11110);
        pulse_return();
        chk("R7 outer restore", mode_o, 4'b1101);
        chk("R7 outer enables", ens(), 5'b10100);
        pulse_return();
        chk("R8 empty return mode", mode_o, 4'b1101);
        chk("R8 empty return enables", ens(), 5'b10100);

        // R10: entry beats a same-cycle write
        write_mode(4'b1001);
        irq_enter = 1'b1; sr_wr = 1'b1; sr_wdata = 4'b1111;
        step();
        irq_enter = 1'b0; sr_wr = 1'b0;
        step();
        chk("R10 enter over write", mode_o, 4'b0000);
        pulse_return();
        chk("R10 saved mode not the write", mode_o, 4'b1001);

        // R10: entry beats a same-cycle return
        irq_enter = 1'b1; irq_return = 1'b1;
        step();
        irq_enter = 1'b0; irq_return = 1'b0;
        step();
        chk("R10 enter over return", mode_o, 4'b0000);
        pulse_return();
        chk("R10 entry was saved", mode_o, 4'b1001);

        // R10: return beats a same-cycle write
        pulse_enter();
        irq_return = 1'b1; sr_wr = 1'b1; sr_wdata = 4'b0001;
        step();
        irq_return = 1'b0; sr_wr = 1'b0;
        step();
        chk("R10 return over write", mode_o, 4'b1001);

        // R1: reset from LPM4
        write_mode(4'b1111);
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
        chk("R1 mid-run reset mode", mode_o, 4'b0000);
        chk("R1 mid-run reset enables", ens(), 5'b11111);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule